// File: doc/BRIEF.md
# Static Memory Bank Router with Wrap Splitting

This block sits between an internal burst bus and the request stage of an external NOR/PSRAM controller. Each incoming request carries a 28-bit byte address, a beat count and a wrap flag. The two top address bits pick one of four banks. The block raises that bank's chip-select. It then converts the low 26 bits into the word address the memory expects, based on the bank's configured data width (8 or 16 bits).

A wrapping request is one whose beat count is 8 or 16 and whose wrap flag is set. It is forwarded as one wrapped burst only when the selected bank has wrapping enabled and its programmed wrap length equals the request's beat count. Otherwise it becomes linear bursts issued back to back:
- The first burst runs from the start word up to the end of the aligned block.
- The second burst restarts at the block base and covers the remaining beats.

When the start word is already on the block boundary, only one linear burst is issued. Each output request also carries a marker, taken from the bank's synchronous-mode bit, telling the pin stage to send the address once per burst.

Both request interfaces use valid/ready:
- An input request is taken on a cycle where `in_valid` and `in_ready` are both high.
- An output request is consumed on a cycle where `out_valid` and `out_ready` are both high.
- While `out_valid` is high and `out_ready` is low, every output field holds still.
- `in_ready` is low while a second split part is still queued, and also while an output is stalled. Requests therefore leave in the order they came in.

Top module: `smc_bank_router`

## Requirements
- R1: `out_cs` is one-hot while `out_valid` is high, with bit k set for the bank given by `in_addr[27:26]` = k of the originating request.
- R2: For a bank whose `cfg_w16` bit is 0 (8-bit memory), `out_addr` equals `in_addr[25:0]` for a non-split request.
- R3: For a bank whose `cfg_w16` bit is 1 (16-bit memory), the word address is `in_addr[25:1]` zero-extended to 26 bits, so byte bit 0 is ignored.
- R4: A request with `in_wrap`=0, or with `in_wrap`=1 and a beat count other than 8 or 16, leaves as one burst with the same beat count and `out_wrap`=0.
- R5: Consider a wrapping request of N beats (N = 8 or 16) to a bank whose `cfg_wrap_en` bit is 1. If that bank's `cfg_wrap16` bit selects the same length (0 means 8, 1 means 16), the request leaves as one burst of N beats at the start word with `out_wrap`=1.
- R6: Any other wrapping request with word offset m = word mod N, where m is not 0, leaves as two linear bursts in order. The first is (start word, N-m beats). The second is (start word - m, m beats).
- R7: A wrapping request that must be split and has m = 0 leaves as one linear burst of N beats, with no empty second part.
- R8: While `out_valid` is high and `out_ready` is low, the output fields hold. `in_ready` is low while a second part is pending or while the output is stalled.
- R9: A request to a bank whose `cfg_bank_en` bit is 0 produces no output request, and `err` is high for exactly the one cycle following its acceptance.
- R10: `out_sync` equals the selected bank's `cfg_sync` bit on every part of the request.
- R11: After reset, `out_valid` and `err` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_bank_en | input | 4 | Per-bank enable |
| cfg_w16 | input | 4 | Per-bank memory width, 1 = 16-bit |
| cfg_wrap_en | input | 4 | Per-bank wrap support |
| cfg_wrap16 | input | 4 | Per-bank wrap length, 0 = 8, 1 = 16 words |
| cfg_sync | input | 4 | Per-bank synchronous mode (address sent once) |
| in_valid | input | 1 | Input request valid |
| in_ready | output | 1 | Input request ready |
| in_addr | input | 28 | Byte address |
| in_beats | input | 5 | Beat count, 1 to 16 |
| in_wrap | input | 1 | Wrapping burst flag |
| out_valid | output | 1 | Output request valid |
| out_ready | input | 1 | Output request ready |
| out_cs | output | 4 | One-hot bank chip-select |
| out_addr | output | 26 | Start word address |
| out_beats | output | 5 | Beat count of this burst |
| out_wrap | output | 1 | Burst is wrapped |
| out_sync | output | 1 | Address-once marker |
| err | output | 1 | Disabled-bank pulse |

## Verification
The first output part is registered and becomes visible one cycle after the accepting edge. A queued second part appears one cycle after the first is consumed. The `err` pulse appears in the same cycle as a first part would have, and is gone the cycle after that. The bench drives inputs on the falling edge and samples at the falling edge after each edge that matters. It compares every field against an arithmetic model of the address and split rules.

Under stalls, the bench holds `out_ready` low for two cycles. It checks that the fields stay put and that `in_ready` stays low. It then confirms that the queue drains to idle one cycle after the last part is consumed.

// File: rtl/smc_pkg.sv
package smc_pkg;
  parameter int NBANK   = 4;
  parameter int BSEL_W  = $clog2(NBANK);
  parameter int MEM_AW  = 26;
  parameter int ADDR_W  = MEM_AW + BSEL_W;
  parameter int MAX_WRAP = 16;
  parameter int OFS_W   = $clog2(MAX_WRAP);
  parameter int BEAT_W  = OFS_W + 1;

  typedef struct packed {
    logic [MEM_AW-1:0] addr;
    logic [BEAT_W-1:0] beats;
    logic              wrap;
  } part_t;
endpackage

// File: rtl/smc_addr_xlate.sv
module smc_addr_xlate
  import smc_pkg::*;
(
  input  logic [ADDR_W-1:0] byte_addr,
  input  logic [NBANK-1:0]  cfg_w16,
  output logic [BSEL_W-1:0] bank,
  output logic [NBANK-1:0]  cs,
  output logic [MEM_AW-1:0] word_addr
);
  assign bank = byte_addr[ADDR_W-1 -: BSEL_W];

  for (genvar k = 0; k < NBANK; k++) begin : g_cs
    assign cs[k] = (bank == BSEL_W'(k));
  end

  always_comb begin
    if (cfg_w16[bank]) word_addr = {1'b0, byte_addr[MEM_AW-1:1]};
    else               word_addr = byte_addr[MEM_AW-1:0];
  end
endmodule

// File: rtl/smc_wrap_split.sv
module smc_wrap_split
  import smc_pkg::*;
(
  input  logic [MEM_AW-1:0] word_addr,
  input  logic [BEAT_W-1:0] beats,
  input  logic              wrap,
  input  logic              bank_wrap_en,
  input  logic              bank_wrap16,
  output part_t             p1,
  output part_t             p2,
  output logic              has_p2
);
  localparam logic [BEAT_W-1:0] LEN_S = BEAT_W'(MAX_WRAP / 2);
  localparam logic [BEAT_W-1:0] LEN_L = BEAT_W'(MAX_WRAP);

  logic             is_len, len_match, pass;
  logic [OFS_W-1:0] mask, ofs;

  always_comb begin
    is_len    = (beats == LEN_S) || (beats == LEN_L);
    len_match = bank_wrap16 ? (beats == LEN_L) : (beats == LEN_S);
    pass      = wrap && is_len && bank_wrap_en && len_match;
    mask      = (beats == LEN_L) ? {OFS_W{1'b1}} : {1'b0, {(OFS_W-1){1'b1}}};
    ofs       = word_addr[OFS_W-1:0] & mask;
    has_p2    = wrap && is_len && !pass && (ofs != '0);

    p1.addr   = word_addr;
    p1.beats  = has_p2 ? beats - {1'b0, ofs} : beats;
    p1.wrap   = pass;

    p2.addr   = word_addr & ~{{(MEM_AW-OFS_W){1'b0}}, mask};
    p2.beats  = {1'b0, ofs};
    p2.wrap   = 1'b0;
  end
endmodule

// File: rtl/smc_bank_router.sv
module smc_bank_router
  import smc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NBANK-1:0]  cfg_bank_en,
  input  logic [NBANK-1:0]  cfg_w16,
  input  logic [NBANK-1:0]  cfg_wrap_en,
  input  logic [NBANK-1:0]  cfg_wrap16,
  input  logic [NBANK-1:0]  cfg_sync,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [BEAT_W-1:0] in_beats,
  input  logic              in_wrap,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [NBANK-1:0]  out_cs,
  output logic [MEM_AW-1:0] out_addr,
  output logic [BEAT_W-1:0] out_beats,
  output logic              out_wrap,
  output logic              out_sync,
  output logic              err
);
  logic [BSEL_W-1:0] bank;
  logic [NBANK-1:0]  cs;
  logic [MEM_AW-1:0] word_addr;
  part_t             p1, p2, cur_q, p2_q;
  logic              has_p2, pend_q, valid_q, sync_q, err_q, accept, bank_ok;
  logic [NBANK-1:0]  cs_q;

  smc_addr_xlate u_xlate (
    .byte_addr (in_addr),
    .cfg_w16   (cfg_w16),
    .bank      (bank),
    .cs        (cs),
    .word_addr (word_addr)
  );

  smc_wrap_split u_split (
    .word_addr    (word_addr),
    .beats        (in_beats),
    .wrap         (in_wrap),
    .bank_wrap_en (cfg_wrap_en[bank]),
    .bank_wrap16  (cfg_wrap16[bank]),
    .p1           (p1),
    .p2           (p2),
    .has_p2       (has_p2)
  );

  assign in_ready = !pend_q && (!valid_q || out_ready);
  assign accept   = in_valid && in_ready;
  assign bank_ok  = cfg_bank_en[bank];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      pend_q  <= 1'b0;
      err_q   <= 1'b0;
      sync_q  <= 1'b0;
      cs_q    <= '0;
      cur_q   <= '0;
      p2_q    <= '0;
    end else begin
      err_q <= accept && !bank_ok;
      if (valid_q && out_ready) begin
        if (pend_q) begin
          cur_q  <= p2_q;
          pend_q <= 1'b0;
        end else begin
          valid_q <= 1'b0;
        end
      end
      if (accept && bank_ok) begin
        cur_q   <= p1;
        p2_q    <= p2;
        pend_q  <= has_p2;
        valid_q <= 1'b1;
        cs_q    <= cs;
        sync_q  <= cfg_sync[bank];
      end
    end
  end

  assign out_valid = valid_q;
  assign out_cs    = cs_q;
  assign out_addr  = cur_q.addr;
  assign out_beats = cur_q.beats;
  assign out_wrap  = cur_q.wrap;
  assign out_sync  = sync_q;
  assign err       = err_q;
endmodule

// File: rtl/smc_router_chk.sv
module smc_router_chk
  import smc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [NBANK-1:0]  out_cs,
  input logic [MEM_AW-1:0] out_addr,
  input logic [BEAT_W-1:0] out_beats,
  input logic              out_wrap,
  input logic              err
);
  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones(out_cs) == 1); // R1

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_beats) && $stable(out_cs) && $stable(out_wrap))); // R8

  AST_NO_TAKE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R8

  AST_WRAP_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_wrap) |-> (out_beats == BEAT_W'(8) || out_beats == BEAT_W'(16))); // R5

  AST_NO_EMPTY_PART: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_beats != '0)); // R7

  AST_ERR_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(in_valid && in_ready)); // R9

  AST_ERR_NO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !out_valid); // R9
endmodule

bind smc_bank_router smc_router_chk u_chk (.*);

// File: tb/sim_smc_bank_router.sv
`timescale 1ns/1ps
module sim_smc_bank_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_bank_en = 4'hF, cfg_w16 = '0, cfg_wrap_en = '0, cfg_wrap16 = '0, cfg_sync = '0;
  logic        in_valid = 1'b0, in_wrap = 1'b0, out_ready = 1'b1;
  logic [27:0] in_addr = '0;
  logic [4:0]  in_beats = 5'd1;
  logic        in_ready, out_valid, out_wrap, out_sync, err;
  logic [3:0]  out_cs;
  logic [25:0] out_addr;
  logic [4:0]  out_beats;
  int vec = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  smc_bank_router u0 (.*);

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_part(input string req, input logic [1:0] bk, input logic [25:0] a,
                          input logic [4:0] nb, input logic wr, input logic sy);
    chk(req, "valid", 32'(out_valid), 1);
    chk("R1", "cs", 32'(out_cs), 32'(4'b1 << bk));
    chk(req, "addr", 32'(out_addr), 32'(a));
    chk(req, "beats", 32'(out_beats), 32'(nb));
    chk(req, "wrap", 32'(out_wrap), 32'(wr));
    chk("R10", "sync", 32'(out_sync), 32'(sy));
  endtask

  task automatic run_req(input logic [1:0] bk, input logic [25:0] a26, input logic [4:0] nb,
                         input logic wr, input logic stall);
    logic [25:0] w, a1, a2;
    logic [4:0]  b1, b2;
    logic        wr1, two, sy;
    int          m;
    string       tag;
    w   = cfg_w16[bk] ? {1'b0, a26[25:1]} : a26;
    sy  = cfg_sync[bk];
    a1 = w; b1 = nb; wr1 = 1'b0; two = 1'b0; a2 = '0; b2 = '0;
    tag = cfg_w16[bk] ? "R3" : "R2";
    if (wr && (nb == 8 || nb == 16)) begin
      if (cfg_wrap_en[bk] && ((cfg_wrap16[bk] ? 16 : 8) == int'(nb))) begin
        wr1 = 1'b1; tag = "R5";
      end else begin
        m = int'(w) % int'(nb);
        if (m == 0) tag = "R7";
        else begin
          tag = "R6"; two = 1'b1;
          b1 = nb - 5'(m); a2 = w - 26'(m); b2 = 5'(m);
        end
      end
    end else if (wr || nb != 1) tag = "R4";
    @(negedge clk);
    chk("R11", "in_ready idle", 32'(in_ready), 1);
    in_addr = {bk, a26}; in_beats = nb; in_wrap = wr; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    if (!cfg_bank_en[bk]) begin
      chk("R9", "err pulse", 32'(err), 1);
      chk("R9", "no output", 32'(out_valid), 0);
      @(negedge clk);
      chk("R9", "err ends", 32'(err), 0);
      chk("R9", "still no output", 32'(out_valid), 0);
      return;
    end
    chk("R9", "no err", 32'(err), 0);
    chk_part(tag, bk, a1, b1, wr1, sy);
    if (stall) begin
      out_ready = 1'b0;
      for (int i = 0; i < 2; i++) begin
        @(negedge clk);
        chk_part("R8", bk, a1, b1, wr1, sy);
        chk("R8", "in_ready stalled", 32'(in_ready), 0);
      end
      out_ready = 1'b1;
    end
    if (two) begin
      chk("R8", "in_ready pending", 32'(in_ready), 0);
      @(negedge clk);
      chk_part("R6", bk, a2, b2, 1'b0, sy);
    end
    @(negedge clk);
    chk(tag, "drained", 32'(out_valid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; vec++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    int n;
    n = 0;
    repeat (3) @(negedge clk);
    chk("R11", "out_valid reset", 32'(out_valid), 0);
    chk("R11", "err reset", 32'(err), 0);
    chk("R11", "in_ready reset", 32'(in_ready), 1);
    rst_n = 1'b1;
    // wrap sweep: bank x width x mode x length x offset
    for (int bk = 0; bk < 4; bk++)
      for (int w16 = 0; w16 < 2; w16++)
        for (int md = 0; md < 3; md++)
          for (int ln = 0; ln < 2; ln++)
            for (int off = 0; off < 16; off++) begin
              cfg_w16     = {4{w16[0]}};
              cfg_wrap_en = {4{md != 0}};
              cfg_wrap16  = {4{md == 2}};
              cfg_sync    = {4{md[0] ^ off[0]}};
              n++;
              run_req(2'(bk), 26'h2A56400 + 26'(w16 ? off * 2 + (off & 1) : off),
                      ln ? 5'd16 : 5'd8, 1'b1, (n % 5) == 0);
            end
    // linear requests, including wrap flag with a non-wrap length
    cfg_wrap_en = 4'hF; cfg_wrap16 = 4'h0;
    for (int nb = 1; nb <= 16; nb++)
      for (int w16 = 0; w16 < 2; w16++) begin
        cfg_w16 = {4{w16[0]}};
        run_req(2'(nb % 4), 26'h1000000 + 26'(nb * 3), 5'(nb), (nb != 8 && nb != 16) && nb[0], nb[1]);
      end
    // disabled bank
    cfg_bank_en = 4'b1011;
    run_req(2'd2, 26'h0000123, 5'd8, 1'b1, 1'b0);
    run_req(2'd2, 26'h0000040, 5'd4, 1'b0, 1'b0);
    run_req(2'd3, 26'h0000045, 5'd16, 1'b1, 1'b1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule